// File: doc/BRIEF.md
# Interrupt Status and Coalescing Controller

This block keeps the interrupt cause register and the interrupt enable mask of a network controller, and drives the one interrupt line that goes to the host. Event sources inside the controller post cause bits into the status register. Software clears them by writing a clear vector. After every accepted post the block checks whether any enabled cause is pending. If one is, it schedules the host line.

Causes fall into two groups. Completion causes can be coalesced: receive OK, receive descriptor, transmit OK and transmit descriptor. When only these causes are pending and enabled, the line waits a programmable number of cycles before it rises. Any other enabled pending cause raises the line on the next cycle. If such a cause arrives during a countdown, the countdown is cancelled. Unimplemented cause bits are dropped and reported on a warning strobe. Any attempt to post or clear the reserved top bit is refused and reported on an error strobe.

The line is controlled by a three-state machine:
- `ST_IDLE` means nothing is scheduled.
- `ST_COUNT` means a coalescing countdown is running.
- `ST_PEND` means the host line is high.

Its transitions are:
- `T_IDLE_PEND`: an immediate trigger, or a deferred trigger with a zero delay.
- `T_IDLE_COUNT`: a deferred trigger with a nonzero delay.
- `T_COUNT_PEND`: the count expires, or an immediate trigger cancels the countdown.
- `T_PEND_IDLE`: a host acknowledge arrives with no trigger in the same cycle.
- `T_PEND_RESCHED`: a host acknowledge arrives together with a trigger, and the trigger is scheduled again.

Top module: `intr_coalesce_ctrl`

## Requirements
- R1: When bit 31 is set in a valid post or a valid clear, both operations of that cycle are refused and the status register keeps its value. `rsv_err_o` is high for one cycle, in the cycle after the request.
- R2: Only bits 0 to 7 are stored. The bit map is:
  - bit 0: receive OK
  - bit 1: receive descriptor
  - bit 2: transmit descriptor
  - bit 3: transmit OK
  - bit 4: software interrupt
  - bit 5: transmit idle
  - bit 6: receive overrun
  - bit 7: receive idle

  A posted bit in the range 30 to 8 is discarded, and `unimpl_warn_o` is high for one cycle, in the cycle after the post.
- R3: A post ORs the filtered bits into the status register. A clear removes the filtered bits. When a post and a clear of the same bit arrive in one cycle, the clear wins. The result shows on `status_o` in the next cycle.
- R4: A mask write loads `mask_wdata_i`, and the new value shows on `mask_o` in the next cycle. A mask write never schedules the line by itself.
- R5: An accepted post, even one with no bits, is a trigger when (new status AND current mask) is nonzero. When that AND is zero, the line is not scheduled.
- R6: If a trigger leaves any enabled pending cause outside bits {0,1,2,3}, `irq_o` is high in the cycle after the post.
- R7: If a trigger leaves only enabled pending causes inside bits {0,1,2,3}, `irq_o` rises `delay_cfg_i` cycles later than it would for an immediate cause. A delay of 0 behaves as immediate.
- R8: An immediate trigger during a countdown raises `irq_o` in the next cycle and cancels the countdown.
- R9: While `irq_o` is high, further posts do not change it. `host_ack_i` drops it in the next cycle. An acknowledge while `irq_o` is low, including during a countdown, has no effect.
- R10: After reset, the status register, the mask register, `irq_o` and both strobes are zero, and no countdown is running.
- R11: An acknowledge and a trigger in the same cycle schedule the trigger again under the rules of R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid_i | input | 1 | Post request |
| post_bits_i | input | 32 | Cause bits to set |
| clr_valid_i | input | 1 | Clear request |
| clr_bits_i | input | 32 | Cause bits to clear |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 32 | Mask register write data |
| delay_cfg_i | input | 16 | Coalescing delay in cycles |
| host_ack_i | input | 1 | Host clears the pending line |
| status_o | output | 32 | Interrupt status register |
| mask_o | output | 32 | Interrupt mask register |
| irq_o | output | 1 | Interrupt line to the host |
| rsv_err_o | output | 1 | Reserved-bit access strobe |
| unimpl_warn_o | output | 1 | Unimplemented-cause strobe |

## Verification
A status bit that is wrongly kept or dropped shows on `status_o` one cycle after the post or clear. A wrong group decision, or a countdown that is miscounted or not cancelled, moves the rising edge of `irq_o` away from its expected cycle. Because the bench compares every output in every cycle against a reference model, the fault is reported in the first cycle where the edge is wrong. A pending state that is lost or stuck shows as `irq_o` falling without an acknowledge, or staying high after one, in the following cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PEND  = 2'd2
    } isc_state_e;

    function automatic logic [31:0] bit_at(input int unsigned pos);
        logic [31:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/isc_cause_filter.sv
module isc_cause_filter #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              post_valid_i,
    input  logic [DATA_W-1:0] post_bits_i,
    input  logic              clr_valid_i,
    input  logic [DATA_W-1:0] clr_bits_i,
    output logic [DATA_W-1:0] post_f_o,
    output logic [DATA_W-1:0] clr_f_o,
    output logic              post_ok_o,
    output logic              rsv_hit_o,
    output logic              unimpl_hit_o
);
    localparam int unsigned RSV_BIT = DATA_W - 1;

    logic rsv_post;
    logic rsv_clr;

    always_comb begin
        rsv_post     = post_valid_i && post_bits_i[RSV_BIT];
        rsv_clr      = clr_valid_i && clr_bits_i[RSV_BIT];
        rsv_hit_o    = rsv_post || rsv_clr;
        post_ok_o    = post_valid_i && !rsv_hit_o;
        post_f_o     = post_ok_o ? (post_bits_i & IMPL_MASK) : '0;
        clr_f_o      = (clr_valid_i && !rsv_hit_o) ? (clr_bits_i & IMPL_MASK) : '0;
        unimpl_hit_o = post_ok_o && (|(post_bits_i & ~IMPL_MASK));
    end
endmodule

// File: rtl/isc_status_regs.sv
module isc_status_regs #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL_MASK  = '1,
    parameter logic [DATA_W-1:0] DEFER_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] post_f_i,
    input  logic [DATA_W-1:0] clr_f_i,
    input  logic              post_ok_i,
    input  logic              rsv_hit_i,
    input  logic              unimpl_hit_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              rsv_err_o,
    output logic              unimpl_warn_o,
    output logic              trigger_o,
    output logic              imm_o
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] status_d;
    logic [DATA_W-1:0] live;

    always_comb begin
        status_d  = (status_q | post_f_i) & ~clr_f_i;
        live      = status_d & mask_q;
        trigger_o = post_ok_i && (|live);
        imm_o     = |(live & ~DEFER_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q      <= '0;
            mask_q        <= '0;
            rsv_err_o     <= 1'b0;
            unimpl_warn_o <= 1'b0;
        end else begin
            status_q      <= status_d;
            rsv_err_o     <= rsv_hit_i;
            unimpl_warn_o <= unimpl_hit_i;
            if (mask_we_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    assert_rsv_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_hit_i |=> (status_q == $past(status_q)));

    assert_only_impl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~IMPL_MASK) == '0);

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_q == $past(mask_wdata_i)));
endmodule

// File: rtl/isc_coalesce_fsm.sv
module isc_coalesce_fsm
    import isc_pkg::*;
#(
    parameter int unsigned DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trigger_i,
    input  logic               imm_i,
    input  logic               ack_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               irq_o
);
    localparam logic [DELAY_W-1:0] CNT_ONE = DELAY_W'(1);

    isc_state_e         state_q;
    isc_state_e         state_d;
    logic [DELAY_W-1:0] cnt_q;
    logic [DELAY_W-1:0] cnt_d;
    logic               go_now;

    always_comb begin
        go_now  = imm_i || (delay_i == '0);
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trigger_i) begin
                    if (go_now) begin
                        state_d = ST_PEND;
                    end else begin
                        state_d = ST_COUNT;
                        cnt_d   = delay_i;
                    end
                end
            end
            ST_COUNT: begin
                if ((trigger_i && imm_i) || (cnt_q == CNT_ONE)) begin
                    state_d = ST_PEND;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_PEND: begin
                if (ack_i) begin
                    if (!trigger_i) begin
                        state_d = ST_IDLE;
                    end else if (!go_now) begin
                        state_d = ST_COUNT;
                        cnt_d   = delay_i;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_PEND);
    end

    assert_imm_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger_i && imm_i) |=> irq_o);

    assert_count_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q != '0));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COUNT) && !trigger_i && (cnt_q > CNT_ONE)) |=>
            ((state_q == ST_COUNT) && (cnt_q == $past(cnt_q) - CNT_ONE)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);

    assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !trigger_i && (state_q == ST_IDLE)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/intr_coalesce_ctrl.sv
module intr_coalesce_ctrl
    import isc_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned DELAY_W    = 16,
    parameter int unsigned POS_RXOK   = 0,
    parameter int unsigned POS_RXDESC = 1,
    parameter int unsigned POS_TXDESC = 2,
    parameter int unsigned POS_TXOK   = 3,
    parameter int unsigned POS_SWI    = 4,
    parameter int unsigned POS_TXIDLE = 5,
    parameter int unsigned POS_RXORN  = 6,
    parameter int unsigned POS_RXIDLE = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid_i,
    input  logic [DATA_W-1:0]  post_bits_i,
    input  logic               clr_valid_i,
    input  logic [DATA_W-1:0]  clr_bits_i,
    input  logic               mask_we_i,
    input  logic [DATA_W-1:0]  mask_wdata_i,
    input  logic [DELAY_W-1:0] delay_cfg_i,
    input  logic               host_ack_i,
    output logic [DATA_W-1:0]  status_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic               irq_o,
    output logic               rsv_err_o,
    output logic               unimpl_warn_o
);
    localparam logic [31:0] DEFER_W32 =
        bit_at(POS_RXOK) | bit_at(POS_RXDESC) | bit_at(POS_TXDESC) | bit_at(POS_TXOK);
    localparam logic [31:0] IMPL_W32 = DEFER_W32 |
        bit_at(POS_SWI) | bit_at(POS_TXIDLE) | bit_at(POS_RXORN) | bit_at(POS_RXIDLE);
    localparam logic [DATA_W-1:0] DEFER_MASK = DATA_W'(DEFER_W32);
    localparam logic [DATA_W-1:0] IMPL_MASK  = DATA_W'(IMPL_W32) & ~(DATA_W'(1) << (DATA_W - 1));

    logic [DATA_W-1:0] post_f;
    logic [DATA_W-1:0] clr_f;
    logic              post_ok;
    logic              rsv_hit;
    logic              unimpl_hit;
    logic              trigger;
    logic              imm;

    isc_cause_filter #(
        .DATA_W    (DATA_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_filter (
        .post_valid_i (post_valid_i),
        .post_bits_i  (post_bits_i),
        .clr_valid_i  (clr_valid_i),
        .clr_bits_i   (clr_bits_i),
        .post_f_o     (post_f),
        .clr_f_o      (clr_f),
        .post_ok_o    (post_ok),
        .rsv_hit_o    (rsv_hit),
        .unimpl_hit_o (unimpl_hit)
    );

    isc_status_regs #(
        .DATA_W     (DATA_W),
        .IMPL_MASK  (IMPL_MASK),
        .DEFER_MASK (DEFER_MASK)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .post_f_i      (post_f),
        .clr_f_i       (clr_f),
        .post_ok_i     (post_ok),
        .rsv_hit_i     (rsv_hit),
        .unimpl_hit_i  (unimpl_hit),
        .mask_we_i     (mask_we_i),
        .mask_wdata_i  (mask_wdata_i),
        .status_o      (status_o),
        .mask_o        (mask_o),
        .rsv_err_o     (rsv_err_o),
        .unimpl_warn_o (unimpl_warn_o),
        .trigger_o     (trigger),
        .imm_o         (imm)
    );

    isc_coalesce_fsm #(
        .DELAY_W (DELAY_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (trigger),
        .imm_i     (imm),
        .ack_i     (host_ack_i),
        .delay_i   (delay_cfg_i),
        .irq_o     (irq_o)
    );

    assert_strobe_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsv_err_o && unimpl_warn_o));
endmodule

// File: tb/intr_coalesce_ctrl_bench.sv
module intr_coalesce_ctrl_bench;

    typedef struct {
        logic [31:0] status;
        logic [31:0] mask;
        logic        irq;
        logic        err;
        logic        warn;
        string       tag;
    } exp_t;

    localparam logic [31:0] IMPL  = 32'h0000_00FF;
    localparam logic [31:0] DEFER = 32'h0000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [31:0] post_bits = '0;
    logic        clr_valid = 1'b0;
    logic [31:0] clr_bits = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic [15:0] delay_cfg = '0;
    logic        host_ack = 1'b0;
    logic [31:0] status_o;
    logic [31:0] mask_o;
    logic        irq_o;
    logic        rsv_err_o;
    logic        unimpl_warn_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    logic [31:0] m_status = '0;
    logic [31:0] m_mask = '0;
    logic        m_pend = 1'b0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    intr_coalesce_ctrl u_intr_coalesce_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .post_valid_i  (post_valid),
        .post_bits_i   (post_bits),
        .clr_valid_i   (clr_valid),
        .clr_bits_i    (clr_bits),
        .mask_we_i     (mask_we),
        .mask_wdata_i  (mask_wdata),
        .delay_cfg_i   (delay_cfg),
        .host_ack_i    (host_ack),
        .status_o      (status_o),
        .mask_o        (mask_o),
        .irq_o         (irq_o),
        .rsv_err_o     (rsv_err_o),
        .unimpl_warn_o (unimpl_warn_o)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops one expectation per cycle and compares it.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (status_o !== e.status || mask_o !== e.mask || irq_o !== e.irq ||
                rsv_err_o !== e.err || unimpl_warn_o !== e.warn) begin
                fails++;
                $display("FAIL %s: got st=%h mk=%h irq=%b err=%b warn=%b exp st=%h mk=%h irq=%b err=%b warn=%b",
                         e.tag, status_o, mask_o, irq_o, rsv_err_o, unimpl_warn_o,
                         e.status, e.mask, e.irq, e.err, e.warn);
            end
        end
    end

    // Driver: applies one cycle of stimulus and pushes the model's result.
    task automatic step(input logic pv, input logic [31:0] pb,
                        input logic cv, input logic [31:0] cb,
                        input logic mw, input logic [31:0] md,
                        input logic ack, input string tag);
        logic rsv;
        logic pok;
        logic [31:0] pf;
        logic [31:0] cf;
        logic [31:0] st_n;
        logic trig;
        logic imm;
        logic warn;
        exp_t e;
        @(negedge clk);
        post_valid = pv; post_bits = pb; clr_valid = cv; clr_bits = cb;
        mask_we = mw; mask_wdata = md; host_ack = ack;
        rsv  = (pv && pb[31]) || (cv && cb[31]);
        pok  = pv && !rsv;
        pf   = pok ? (pb & IMPL) : 32'h0;
        cf   = (cv && !rsv) ? (cb & IMPL) : 32'h0;
        warn = pok && ((pb & ~IMPL) != 32'h0);
        st_n = (m_status | pf) & ~cf;
        trig = pok && ((st_n & m_mask) != 32'h0);
        imm  = ((st_n & m_mask & ~DEFER) != 32'h0);
        if (m_pend) begin
            if (ack) begin
                m_pend = 1'b0;
                if (trig) begin
                    if (imm || delay_cfg == 0) m_pend = 1'b1;
                    else m_cnt = delay_cfg;
                end
            end
        end else if (m_cnt > 0) begin
            if ((trig && imm) || m_cnt == 1) begin
                m_pend = 1'b1;
                m_cnt  = 0;
            end else begin
                m_cnt--;
            end
        end else if (trig) begin
            if (imm || delay_cfg == 0) m_pend = 1'b1;
            else m_cnt = delay_cfg;
        end
        m_status = st_n;
        if (mw) m_mask = md;
        e.status = m_status; e.mask = m_mask; e.irq = m_pend;
        e.err = rsv; e.warn = warn; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic post(input logic [31:0] b, input string tag);
        step(1, b, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic clr(input logic [31:0] b, input string tag);
        step(0, 0, 1, b, 0, 0, 0, tag);
    endtask

    task automatic ack(input string tag);
        step(0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic wmask(input logic [31:0] m, input string tag);
        step(0, 0, 0, 0, 1, m, 0, tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got hung run exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (status_o !== 0 || mask_o !== 0 || irq_o !== 0 || rsv_err_o !== 0 || unimpl_warn_o !== 0) begin
            fails++;
            $display("FAIL R10 reset: got st=%h mk=%h irq=%b exp all zero", status_o, mask_o, irq_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R10 idle after reset");

        wmask(32'h0000_00FF, "R4 mask write");
        delay_cfg = 16'd5;
        post(32'h1, "R7 deferred rxok");
        idle(7, "R7 countdown");
        ack("R9 ack clears");
        ack("R9 ack while low");
        clr(32'h1, "R3 clear bit0");

        post(32'h10, "R6 immediate swi");
        post(32'h20, "R9 post while pending");
        idle(1, "R9 hold");
        ack("R9 ack");
        clr(32'h30, "R3 clear swi txidle");

        delay_cfg = 16'd20;
        post(32'h2, "R7 deferred rxdesc");
        idle(2, "R7 counting");
        ack("R9 ack during countdown ignored");
        post(32'h40, "R8 immediate cancels countdown");
        idle(3, "R8 no second edge");
        ack("R8 ack");
        clr(32'hFF, "R3 clear all");
        idle(25, "R8 cancelled countdown stays quiet");

        post(32'h8000_0001, "R1 reserved post");
        clr(32'h8000_0000, "R1 reserved clear");
        post(32'h4, "R1 setup");
        idle(22, "R7 drain");
        ack("R1 ack");
        clr(32'h8000_0004, "R1 reserved clear keeps bit2");
        clr(32'h4, "R3 clear bit2");

        delay_cfg = 16'd0;
        post(32'h0000_0F01, "R2 unimplemented dropped");
        idle(1, "R7 zero delay");
        ack("R2 ack");
        clr(32'h1, "R2 clear");

        wmask(32'h0, "R4 mask zero");
        post(32'h10, "R5 masked no trigger");
        idle(2, "R5 quiet");
        wmask(32'h10, "R4 mask write no trigger");
        idle(2, "R4 quiet after mask");
        post(32'h0, "R5 empty post triggers");
        idle(1, "R5 pending");

        step(1, 32'h18, 1, 32'h18, 0, 0, 0, "R3 clear wins");
        wmask(32'h3, "R4 mask 3");
        clr(32'h10, "R3 clear swi");
        delay_cfg = 16'd4;
        step(1, 32'h2, 0, 0, 0, 0, 1, "R11 ack with deferred trigger");
        idle(6, "R11 rescheduled countdown");
        step(1, 32'h1, 0, 0, 0, 0, 1, "R11 ack with trigger again");
        wmask(32'h13, "R4 mask 13");
        step(1, 32'h10, 0, 0, 0, 0, 0, "R6 setup swi");
        step(1, 32'h0, 0, 0, 0, 0, 1, "R11 ack with immediate trigger");
        idle(2, "R11 stays high");

        idle(3, "drain");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule